// File: doc/BRIEF.md
# Set/Clear GPIO Port Controller

A general-purpose I/O port controller attached to a simple single-cycle register bus. Software never rewrites the output latch as a whole. It changes individual output bits through two write-only locations. One location sets every bit written as 1. The other clears every bit written as 1. Because of this, two agents that share the port cannot overwrite each other's bits with a stale read-modify-write.

A direction register chooses, per pin, whether the pad is driven from the output latch or left floating. The pad side is split into three vectors: a value, an output enable and a sampled input. The pad cell combines them into a tri-state buffer. Pin levels pass through a two-flop synchroniser before they can be read. The output latch has its own read location, so software can always tell what it asked for apart from what the pins actually show.

Each register access is a single-cycle request:

- A write is `bus_sel` and `bus_wr` both high.
- A read is `bus_sel` high with `bus_wr` low.
- Read data is registered. It appears on `bus_rdata` in the cycle after the request and holds until the next read.

Top module: `gpio_setclr_port`

## Requirements
- R1: After reset the output latch and the direction register are all zero, so `pad_oe` and `pad_out` are zero and `bus_rdata` is zero.
- R2: A write to offset 0x00 sets each latch bit whose write-data bit is 1 and leaves the bits written as 0 unchanged; `pad_out` shows the new value from the cycle after the write.
- R3: A write to offset 0x04 clears each latch bit whose write-data bit is 1 and leaves the bits written as 0 unchanged; `pad_out` shows the new value from the cycle after the write.
- R4: Offset 0x08 is the direction register, written with the write data and read back unchanged; a 1 bit selects output, a 0 bit selects input.
- R5: `pad_oe` equals the direction register bit by bit and changes only after a write to offset 0x08; `pad_out` always carries the output latch.
- R6: A read at offset 0x00 returns the pin inputs after two synchronising flops: a pin change presented before a clock edge is returned by a read issued at the third edge from then, and not by reads at the first or second edge.
- R7: A read at offset 0x04 returns the output latch, whatever the direction bits and pin inputs are.
- R8: Accesses to any offset other than 0x00, 0x04 and 0x08 are ignored when writing and return zero when reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Byte offset of the register |
| bus_wdata | input | PORT_W (32) | Write data |
| bus_rdata | output | PORT_W (32) | Registered read data |
| pad_in | input | PORT_W (32) | Asynchronous pin levels from the pads |
| pad_out | output | PORT_W (32) | Output latch value driven to the pads |
| pad_oe | output | PORT_W (32) | Per-pin drive enable, 1 = drive, 0 = tri-state |

## Verification
The latch and direction state can be seen directly on `pad_out` and `pad_oe`. A wrong set, clear or direction update therefore shows up one cycle after the offending write, with no read needed. A fault in the synchroniser depth or in the read multiplexer only appears on `bus_rdata`, one cycle after a read. Pin sweeps therefore read back every pattern, and they also read exactly at the second and third edges after a pin change to pin down the latency. Unmapped offsets are probed by writing all ones, then reading the latch and direction back and watching the pad outputs.

// File: rtl/gpio_setclr_pkg.sv
package gpio_setclr_pkg;

    // Byte offsets; the set/input pair, clear/output pair and direction
    // register are decoded by the bus decoder against these values.
    localparam int unsigned OFS_SET_PINS  = 'h0;
    localparam int unsigned OFS_CLR_LATCH = 'h4;
    localparam int unsigned OFS_DIR       = 'h8;

    // Source of registered read data
    typedef enum logic [1:0] {
        RSEL_NONE  = 2'd0,
        RSEL_PINS  = 2'd1,
        RSEL_LATCH = 2'd2,
        RSEL_DIR   = 2'd3
    } gpio_rsel_e;

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_setclr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              wr_set,
    output logic              wr_clr,
    output logic              wr_dir,
    output logic              rd_en,
    output gpio_rsel_e        rd_sel
);

    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFS_SET_PINS);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_CLR_LATCH);
    localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(OFS_DIR);

    logic hit_set;
    logic hit_clr;
    logic hit_dir;
    logic do_wr;

    always_comb begin
        hit_set = (bus_addr == A_SET);
        hit_clr = (bus_addr == A_CLR);
        hit_dir = (bus_addr == A_DIR);
        do_wr   = bus_sel && bus_wr;

        wr_set  = do_wr && hit_set;
        wr_clr  = do_wr && hit_clr;
        wr_dir  = do_wr && hit_dir;
        rd_en   = bus_sel && !bus_wr;

        if (hit_set)      rd_sel = RSEL_PINS;
        else if (hit_clr) rd_sel = RSEL_LATCH;
        else if (hit_dir) rd_sel = RSEL_DIR;
        else              rd_sel = RSEL_NONE;
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int PORT_W = 32,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pins_async,
    output logic [PORT_W-1:0] pins_sync
);

    typedef struct packed {
        logic [STAGES-1:0][PORT_W-1:0] stage;
    } sync_state_t;

    sync_state_t sync_d;
    sync_state_t sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.stage[0] = pins_async;
        for (int s = 1; s < STAGES; s++) begin
            sync_d.stage[s] = sync_q.stage[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign pins_sync = sync_q.stage[STAGES-1];

endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs #(
    parameter int PORT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic              wr_dir,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] latch_q,
    output logic [PORT_W-1:0] dir_q
);

    typedef struct packed {
        logic [PORT_W-1:0] latch;
        logic [PORT_W-1:0] dir;
    } out_state_t;

    out_state_t regs_d;
    out_state_t regs_q;

    always_comb begin
        regs_d = regs_q;
        // Set applied first, clear last: clear wins on a shared bit
        if (wr_set) regs_d.latch = regs_d.latch | wdata;
        if (wr_clr) regs_d.latch = regs_d.latch & ~wdata;
        if (wr_dir) regs_d.dir   = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign latch_q = regs_q.latch;
    assign dir_q   = regs_q.dir;

endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
    import gpio_setclr_pkg::*;
#(
    parameter int PORT_W      = 32,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe
);

    logic              wr_set;
    logic              wr_clr;
    logic              wr_dir;
    logic              rd_en;
    gpio_rsel_e        rd_sel;
    logic [PORT_W-1:0] pins_sync;
    logic [PORT_W-1:0] latch_q;
    logic [PORT_W-1:0] dir_q;

    gpio_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .wr_set  (wr_set),
        .wr_clr  (wr_clr),
        .wr_dir  (wr_dir),
        .rd_en   (rd_en),
        .rd_sel  (rd_sel)
    );

    gpio_in_sync #(.PORT_W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins_async(pad_in),
        .pins_sync (pins_sync)
    );

    gpio_out_regs #(.PORT_W(PORT_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_set (wr_set),
        .wr_clr (wr_clr),
        .wr_dir (wr_dir),
        .wdata  (bus_wdata),
        .latch_q(latch_q),
        .dir_q  (dir_q)
    );

    typedef struct packed {
        logic [PORT_W-1:0] rdata;
    } rd_state_t;

    rd_state_t rd_d;
    rd_state_t rd_q;

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            unique case (rd_sel)
                RSEL_PINS:  rd_d.rdata = pins_sync;
                RSEL_LATCH: rd_d.rdata = latch_q;
                RSEL_DIR:   rd_d.rdata = dir_q;
                default:    rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;
    assign pad_out   = latch_q;
    assign pad_oe    = dir_q;

endmodule

// File: rtl/gpio_setclr_port_chk.sv
module gpio_setclr_port_chk
    import gpio_setclr_pkg::*;
#(
    parameter int PORT_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PORT_W-1:0] bus_wdata,
    input logic [PORT_W-1:0] bus_rdata,
    input logic [PORT_W-1:0] pad_in,
    input logic [PORT_W-1:0] pad_out,
    input logic [PORT_W-1:0] pad_oe
);

    logic [1:0] cyc_q;
    logic       rst_seen_q;
    logic       is_set;
    logic       is_clr;
    logic       is_dir;
    logic       is_rd;

    always_comb begin
        is_set = bus_addr == ADDR_W'(OFS_SET_PINS);
        is_clr = bus_addr == ADDR_W'(OFS_CLR_LATCH);
        is_dir = bus_addr == ADDR_W'(OFS_DIR);
        is_rd  = bus_sel && !bus_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cyc_q <= '0;
        else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;
    end

    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    // R1
    always @(posedge clk) begin
        if (!rst_n && rst_seen_q) begin
            reset_idle_chk: assert (pad_oe == '0 && pad_out == '0 && bus_rdata == '0);
        end
    end

    // R2
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && is_set) |=> pad_out == ($past(pad_out) | $past(bus_wdata)));

    // R3
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && is_clr) |=> pad_out == ($past(pad_out) & ~$past(bus_wdata)));

    // R4
    dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && is_dir) |=> pad_oe == $past(bus_wdata));

    // R5
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && is_dir) |=> $stable(pad_oe));

    // R6
    pin_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd3 && is_rd && is_set) |=> bus_rdata == $past(pad_in, 3));

    // R7
    latch_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && is_clr) |=> bus_rdata == $past(pad_out));

    // R8
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && !is_set && !is_clr && !is_dir) |=> bus_rdata == '0);

endmodule

bind gpio_setclr_port gpio_setclr_port_chk #(.PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
);

// File: tb/gpio_setclr_port_bench.sv
module gpio_setclr_port_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int AW         = 4;
    localparam int NPAT       = 1 << W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [W-1:0]  pad_in = '0;
    logic [W-1:0]  pad_out;
    logic [W-1:0]  pad_oe;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_setclr_port #(.PORT_W(W), .ADDR_W(AW)) u_gpio_setclr_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pad_in   (pad_in),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [W-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R1..R8 actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [W-1:0] rd;
        logic [W-1:0] model;
        logic [W-1:0] dmodel;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 pad_oe", pad_oe, '0);
        check("R1 pad_out", pad_out, '0);
        check("R1 rdata", bus_rdata, '0);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(4'h4, rd); check("R1 latch read", rd, '0);
        bus_read(4'h8, rd); check("R1 dir read", rd, '0);

        // R2/R3: set then clear sweep over every pattern
        model = '0;
        for (int v = 0; v < NPAT; v++) begin
            bus_write(4'h0, W'(v));
            model = model | W'(v);
            check("R2 pad_out after set", pad_out, model);
            bus_read(4'h4, rd); check("R7 latch after set", rd, model);
            bus_write(4'h4, W'(v * 37 + 5));
            model = model & ~W'(v * 37 + 5);
            check("R3 pad_out after clear", pad_out, model);
        end
        bus_write(4'h4, '1);
        check("R3 clear all", pad_out, '0);

        // R4/R5: direction sweep, latch unaffected
        bus_write(4'h0, 8'hA5);
        model = 8'hA5;
        for (int v = 0; v < NPAT; v++) begin
            bus_write(4'h8, W'(v));
            check("R5 pad_oe follows dir", pad_oe, W'(v));
            bus_read(4'h8, rd); check("R4 dir readback", rd, W'(v));
            check("R5 pad_out independent of dir", pad_out, model);
        end
        dmodel = W'(NPAT - 1);

        // R5: set/clear do not move pad_oe
        bus_write(4'h4, 8'hFF);
        check("R5 oe stable on clear", pad_oe, dmodel);
        bus_write(4'h0, 8'h3C);
        model = 8'h3C;
        check("R5 oe stable on set", pad_oe, dmodel);

        // R6: pin sweep with reads after the synchroniser settles
        for (int v = 0; v < NPAT; v++) begin
            @(negedge clk);
            pad_in = W'(v ^ 8'h5A);
            @(negedge clk);
            @(negedge clk);
            bus_read(4'h0, rd);
            check("R6 pin read", rd, W'(v ^ 8'h5A));
        end

        // R6: exact latency; change presented before edge 1
        @(negedge clk);
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        pad_in = 8'hC3;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'h0;
        @(negedge clk);
        check("R6 read at edge 1 old", bus_rdata, 8'h00);
        @(negedge clk);
        check("R6 read at edge 2 old", bus_rdata, 8'h00);
        @(negedge clk);
        check("R6 read at edge 3 new", bus_rdata, 8'hC3);
        bus_sel = 1'b0;

        // R7: latch read ignores pins and direction
        pad_in = ~model;
        bus_write(4'h8, 8'h00);
        repeat (3) @(negedge clk);
        bus_read(4'h4, rd); check("R7 latch vs pins", rd, model);

        // R8: unmapped offsets
        for (int a = 0; a < (1 << AW); a++) begin
            if (a == 0 || a == 4 || a == 8) continue;
            bus_write(AW'(a), 8'hFF);
            check("R8 pad_out unchanged", pad_out, model);
            check("R8 pad_oe unchanged", pad_oe, 8'h00);
            bus_read(AW'(a), rd); check("R8 unmapped read zero", rd, '0);
        end
        bus_read(4'h8, rd); check("R8 dir intact", rd, 8'h00);
        bus_read(4'h4, rd); check("R8 latch intact", rd, model);

        // R1: reset mid-run returns to idle
        bus_write(4'h8, 8'hF0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 oe after reset", pad_oe, '0);
        check("R1 out after reset", pad_out, '0);
        check("R1 rdata after reset", bus_rdata, '0);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule